// File: doc/BRIEF.md
# Multi-MRU Way Predictor

This block predicts which way of an N-way set-associative cache will hold a requested line. It keeps N small most-recently-used records per set. The lowest log2(N) bits of the request tag pick one of those records, so tags with equal low bits share a record. Each record is a way number. A lookup always yields exactly one predicted way, even when the line is not in the cache at all.

The block also runs the access sequence around that prediction. It first asks the cache to probe only the predicted way. If that way does not hit, it asks for a second probe of every other way. It then reports a fast hit, a slow hit or a miss. A hit makes the record learn the way that hit. A separate fill port lets the refill logic point a record at the victim way it has just written. The tag and data arrays stay outside the block. The cache answers each probe with a per-way hit vector.

Top module: `mmru_predictor`

## Requirements
- R1: After reset every record holds way 0, `lookupReady` is 1, and `resultValid`, `probeStart` and `probeEn` are all 0.
- R2: The record used for a lookup is the one addressed by `lookupSet` together with `lookupTagLow`. Writing one record leaves every other record unchanged.
- R3: A lookup is accepted on a clock edge where `lookupReady` and `lookupValid` are both high. In the next cycle `probeStart` is 1, `predWay` shows the selected record and `probeEn` is the one-hot of `predWay`. If `probeHit[predWay]` is set on the `probeDone` cycle, then in the next cycle `resultValid` is 1, `resultStatus` is 1 (fast hit) and `resultWay` equals the predicted way.
- R4: If the first probe finishes without `probeHit[predWay]`, no result is given. Hit bits on ways that were not enabled are ignored. In the next cycle `probeStart` is 1 again and `probeEn` enables every way except the predicted one.
- R5: If the second probe reports a hit on any enabled way, the result is status 2 (slow hit). `resultWay` is the lowest-numbered enabled way that hit.
- R6: If the second probe reports no enabled hit, the result is status 3 (miss) with `resultWay` equal to the predicted way. The record is left unchanged.
- R7: A fast or slow hit writes the hitting way into the record used for that lookup, so the next lookup of that record predicts it.
- R8: `fillValid` writes `fillWay` into the record addressed by `fillSet` and `fillTagLow`. If it targets the same record in the same cycle as a hit update, the fill value wins.
- R9: While a lookup is in flight, `lookupReady` is 0 and `lookupValid` is ignored. `predWay` and `probeEn` stay unchanged and no new `probeStart` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request |
| lookupSet | input | SET_W | Set index of the request |
| lookupTagLow | input | WAY_W | Lowest log2(N) tag bits of the request |
| lookupReady | output | 1 | Block idle, lookup can be accepted |
| predWay | output | WAY_W | Predicted way of the lookup in flight |
| probeEn | output | NUM_WAYS | Ways the cache must probe now |
| probeStart | output | 1 | One-cycle strobe: a new probe begins |
| probeDone | input | 1 | Cache finished the current probe |
| probeHit | input | NUM_WAYS | Per-way tag match of the finished probe |
| resultValid | output | 1 | One-cycle strobe: outcome available |
| resultStatus | output | 2 | 1 fast hit, 2 slow hit, 3 miss |
| resultWay | output | WAY_W | Hitting way, or predicted way on a miss |
| fillValid | input | 1 | Record update from refill |
| fillSet | input | SET_W | Set of the refilled line |
| fillTagLow | input | WAY_W | Low tag bits of the refilled line |
| fillWay | input | WAY_W | Victim way written by the refill |

## Verification
A corrupted record does not show up as a wrong status. It shows up in `predWay` and the one-hot `probeEn` in the cycle after the next lookup of that record is accepted. So every lookup in the sweep compares the prediction against a bench model of all records, and any stray write to a neighbouring record is caught on its next use. A sequencer that skips or repeats a phase shows up two cycles after acceptance at the latest. It appears as a missing `probeStart`, a wrong enable mask or a result strobe with the wrong status.

// File: rtl/mmru_pkg.sv
package mmru_pkg;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_FAST = 2'd1,
    RES_SLOW = 2'd2,
    RES_MISS = 2'd3
  } resStatus_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef struct packed {
    logic capture;      // latch request, read record
    logic issueProbe;   // a probe begins next cycle
    logic probeFirst;   // first probe in flight
    logic probeSecond;  // fallback probe in flight
    logic finishFast;
    logic finishSlow;
    logic finishMiss;
  } ctrlStrobes_t;

endpackage

// File: rtl/mmru_ctrl.sv
module mmru_ctrl
  import mmru_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lookupValid,
  input  logic         probeDone,
  input  logic         firstHit,
  input  logic         secondHit,
  output logic         lookupReady,
  output ctrlStrobes_t ctrl
);

  phase_e phaseQ, phaseD;

  always_comb begin
    phaseD = phaseQ;
    ctrl   = '0;
    ctrl.probeFirst  = (phaseQ == PH_FIRST);
    ctrl.probeSecond = (phaseQ == PH_SECOND);
    unique case (phaseQ)
      PH_IDLE: begin
        if (lookupValid) begin
          ctrl.capture    = 1'b1;
          ctrl.issueProbe = 1'b1;
          phaseD          = PH_FIRST;
        end
      end
      PH_FIRST: begin
        if (probeDone) begin
          if (firstHit) begin
            ctrl.finishFast = 1'b1;
            phaseD          = PH_IDLE;
          end else begin
            ctrl.issueProbe = 1'b1;
            phaseD          = PH_SECOND;
          end
        end
      end
      PH_SECOND: begin
        if (probeDone) begin
          ctrl.finishSlow = secondHit;
          ctrl.finishMiss = !secondHit;
          phaseD          = PH_IDLE;
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  assign lookupReady = (phaseQ == PH_IDLE);

  // R9: a held request is not re-captured while a lookup is in flight
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!lookupReady && !probeDone) |=> !lookupReady);

endmodule

// File: rtl/mmru_datapath.sv
module mmru_datapath
  import mmru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int IDX_W   = SET_W + WAY_W,
  localparam int ENTRIES = NUM_SETS * NUM_WAYS
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        ctrl,
  input  logic [SET_W-1:0]    lookupSet,
  input  logic [WAY_W-1:0]    lookupTagLow,
  input  logic                probeDone,
  input  logic [NUM_WAYS-1:0] probeHit,
  input  logic                fillValid,
  input  logic [SET_W-1:0]    fillSet,
  input  logic [WAY_W-1:0]    fillTagLow,
  input  logic [WAY_W-1:0]    fillWay,
  output logic [WAY_W-1:0]    predWay,
  output logic [NUM_WAYS-1:0] probeEn,
  output logic                probeStart,
  output logic                resultValid,
  output logic [1:0]          resultStatus,
  output logic [WAY_W-1:0]    resultWay,
  output logic                firstHit,
  output logic                secondHit
);

  function automatic logic [WAY_W-1:0] lowestWay(input logic [NUM_WAYS-1:0] vec);
    logic [WAY_W-1:0] w;
    w = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (vec[i]) w = WAY_W'(i);
    end
    return w;
  endfunction

  logic [WAY_W-1:0]    mruTbl [ENTRIES];
  logic [IDX_W-1:0]    lookupIdx, fillIdx, reqIdxQ;
  logic [WAY_W-1:0]    predQ;
  logic [NUM_WAYS-1:0] predOneHot, restMask;
  logic                hitWr;
  logic [WAY_W-1:0]    hitWay;
  logic                probeStartQ, resultValidQ;
  resStatus_e          statusQ;
  logic [WAY_W-1:0]    resultWayQ;

  assign lookupIdx  = {lookupSet, lookupTagLow};
  assign fillIdx    = {fillSet, fillTagLow};
  assign predOneHot = NUM_WAYS'(1) << predQ;
  assign restMask   = ~predOneHot;

  assign firstHit  = probeHit[predQ];
  assign secondHit = |(probeHit & restMask);

  assign hitWr  = ctrl.finishFast | ctrl.finishSlow;
  assign hitWay = ctrl.finishFast ? predQ : lowestWay(probeHit & restMask);

  // Record storage: one register per (set, low-tag-bits) pair; fill wins.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    mruTbl[e] <= '0;
      else if (fillValid && fillIdx == IDX_W'(e))   mruTbl[e] <= fillWay;
      else if (hitWr && reqIdxQ == IDX_W'(e))       mruTbl[e] <= hitWay;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqIdxQ      <= '0;
      predQ        <= '0;
      probeStartQ  <= 1'b0;
      resultValidQ <= 1'b0;
      statusQ      <= RES_NONE;
      resultWayQ   <= '0;
    end else begin
      probeStartQ  <= ctrl.issueProbe;
      resultValidQ <= ctrl.finishFast | ctrl.finishSlow | ctrl.finishMiss;
      if (ctrl.capture) begin
        reqIdxQ <= lookupIdx;
        predQ   <= mruTbl[lookupIdx];
      end
      if (ctrl.finishFast) begin
        statusQ    <= RES_FAST;
        resultWayQ <= predQ;
      end else if (ctrl.finishSlow) begin
        statusQ    <= RES_SLOW;
        resultWayQ <= hitWay;
      end else if (ctrl.finishMiss) begin
        statusQ    <= RES_MISS;
        resultWayQ <= predQ;
      end
    end
  end

  assign predWay      = predQ;
  assign probeStart   = probeStartQ;
  assign resultValid  = resultValidQ;
  assign resultStatus = statusQ;
  assign resultWay    = resultWayQ;
  assign probeEn      = ctrl.probeFirst  ? predOneHot :
                        ctrl.probeSecond ? restMask   : '0;

  // R3: every result follows a completed probe
  p_result_after_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(probeDone));

  // R3: a probe strobe always comes with at least one enabled way
  p_start_has_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    probeStart |-> (probeEn != '0));

  // R3: a fast hit reports the way that was predicted
  p_fast_way_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultStatus == RES_FAST) |-> (resultWay == $past(predWay)));

  // R4: the fallback probe covers all ways but the predicted one
  p_fallback_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (probeStart && !$past(ctrl.capture)) |->
      (!probeEn[predWay] && $countones(probeEn) == NUM_WAYS - 1));

  // R5: a slow hit never names the way already probed
  p_slow_not_pred_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultStatus == RES_SLOW) |-> (resultWay != $past(predWay)));

  // R6: a miss reports the predicted way
  p_miss_way_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultStatus == RES_MISS) |-> (resultWay == $past(predWay)));

endmodule

// File: rtl/mmru_predictor.sv
module mmru_predictor
  import mmru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [SET_W-1:0]    lookupSet,
  input  logic [WAY_W-1:0]    lookupTagLow,
  output logic                lookupReady,
  output logic [WAY_W-1:0]    predWay,
  output logic [NUM_WAYS-1:0] probeEn,
  output logic                probeStart,
  input  logic                probeDone,
  input  logic [NUM_WAYS-1:0] probeHit,
  output logic                resultValid,
  output logic [1:0]          resultStatus,
  output logic [WAY_W-1:0]    resultWay,
  input  logic                fillValid,
  input  logic [SET_W-1:0]    fillSet,
  input  logic [WAY_W-1:0]    fillTagLow,
  input  logic [WAY_W-1:0]    fillWay
);

  ctrlStrobes_t ctrl;
  logic         firstHit, secondHit;

  mmru_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .probeDone   (probeDone),
    .firstHit    (firstHit),
    .secondHit   (secondHit),
    .lookupReady (lookupReady),
    .ctrl        (ctrl)
  );

  mmru_datapath #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .lookupSet    (lookupSet),
    .lookupTagLow (lookupTagLow),
    .probeDone    (probeDone),
    .probeHit     (probeHit),
    .fillValid    (fillValid),
    .fillSet      (fillSet),
    .fillTagLow   (fillTagLow),
    .fillWay      (fillWay),
    .predWay      (predWay),
    .probeEn      (probeEn),
    .probeStart   (probeStart),
    .resultValid  (resultValid),
    .resultStatus (resultStatus),
    .resultWay    (resultWay),
    .firstHit     (firstHit),
    .secondHit    (secondHit)
  );

endmodule

// File: tb/test_mmru_predictor.sv
`timescale 1ns/1ps
module test_mmru_predictor;

  localparam int NW = 4;
  localparam int NS = 4;
  localparam int WW = 2;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [SW-1:0] lookupSet = '0;
  logic [WW-1:0] lookupTagLow = '0;
  logic          lookupReady;
  logic [WW-1:0] predWay;
  logic [NW-1:0] probeEn;
  logic          probeStart;
  logic          probeDone = 1'b0;
  logic [NW-1:0] probeHit = '0;
  logic          resultValid;
  logic [1:0]    resultStatus;
  logic [WW-1:0] resultWay;
  logic          fillValid = 1'b0;
  logic [SW-1:0] fillSet = '0;
  logic [WW-1:0] fillTagLow = '0;
  logic [WW-1:0] fillWay = '0;

  int checks = 0;
  int errors = 0;
  int model [NS*NW];

  always #2.5 clk = ~clk;

  mmru_predictor #(.NUM_WAYS(NW), .NUM_SETS(NS)) i_mmru_predictor (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupSet(lookupSet), .lookupTagLow(lookupTagLow),
    .lookupReady(lookupReady), .predWay(predWay), .probeEn(probeEn),
    .probeStart(probeStart), .probeDone(probeDone), .probeHit(probeHit),
    .resultValid(resultValid), .resultStatus(resultStatus), .resultWay(resultWay),
    .fillValid(fillValid), .fillSet(fillSet), .fillTagLow(fillTagLow), .fillWay(fillWay)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One complete lookup; hv is the cache's true per-way match vector.
  task automatic access(input int s, input int t, input logic [NW-1:0] hv,
                        input bit poke, input bit fillOn, input int fw);
    int idx, p, st, w;
    logic [NW-1:0] ohP, rest;
    idx  = s * NW + t;
    p    = model[idx];
    ohP  = NW'(1) << p;
    rest = ~ohP;
    w    = p;
    if (hv[p]) st = 1;
    else if ((hv & rest) != '0) begin
      st = 2;
      for (int i = NW - 1; i >= 0; i--) if (hv[i] && i != p) w = i;
    end else st = 3;

    lookupValid = 1'b1; lookupSet = SW'(s); lookupTagLow = WW'(t);
    @(negedge clk);
    lookupValid = 1'b0;
    chk("R3 probeStart after accept", int'(probeStart), 1);
    chk("R2 predWay from selected record", int'(predWay), p);
    chk("R3 probeEn one-hot of prediction", int'(probeEn), int'(ohP));
    chk("R9 lookupReady low while busy", int'(lookupReady), 0);
    if (poke) begin
      lookupValid = 1'b1; lookupSet = SW'((s + 1) % NS); lookupTagLow = WW'((t + 1) % NW);
      @(negedge clk);
      lookupValid = 1'b0;
      chk("R9 no new probeStart", int'(probeStart), 0);
      chk("R9 predWay held", int'(predWay), p);
      chk("R9 probeEn held", int'(probeEn), int'(ohP));
    end
    probeDone = 1'b1; probeHit = hv;
    if (fillOn) begin
      fillValid = 1'b1; fillSet = SW'(s); fillTagLow = WW'(t); fillWay = WW'(fw);
    end
    @(negedge clk);
    probeDone = 1'b0; probeHit = '0; fillValid = 1'b0;
    if (st == 1) begin
      chk("R3 fast resultValid", int'(resultValid), 1);
      chk("R3 fast status", int'(resultStatus), 1);
      chk("R3 fast way", int'(resultWay), p);
    end else begin
      chk("R4 no result after first miss", int'(resultValid), 0);
      chk("R4 second probeStart", int'(probeStart), 1);
      chk("R4 fallback mask", int'(probeEn), int'(rest));
      probeDone = 1'b1; probeHit = hv;
      @(negedge clk);
      probeDone = 1'b0; probeHit = '0;
      chk(st == 2 ? "R5 slow resultValid" : "R6 miss resultValid", int'(resultValid), 1);
      chk(st == 2 ? "R5 slow status" : "R6 miss status", int'(resultStatus), st);
      chk(st == 2 ? "R5 slow way" : "R6 miss way", int'(resultWay), w);
    end
    if (st != 3) model[idx] = w;  // R7 learning
    if (fillOn) model[idx] = fw;  // R8 fill priority
  endtask

  task automatic fill(input int s, input int t, input int w);
    fillValid = 1'b1; fillSet = SW'(s); fillTagLow = WW'(t); fillWay = WW'(w);
    @(negedge clk);
    fillValid = 1'b0;
    model[s * NW + t] = w;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS * NW; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset lookupReady", int'(lookupReady), 1);
    chk("R1 reset resultValid", int'(resultValid), 0);
    chk("R1 reset probeEn", int'(probeEn), 0);
    chk("R1 reset probeStart", int'(probeStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(lookupReady), 1);

    // R1: every record starts at way 0 -> fast hit on way 0
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NW; t++)
        access(s, t, NW'(1), 1'b0, 1'b0, 0);

    // R4/R5/R7: learn a distinct non-zero way per record, then hit fast
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NW; t++) begin
        int w;
        w = (s + t) % (NW - 1) + 1;
        access(s, t, NW'(1) << w, 1'b0, 1'b0, 0);
      end
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NW; t++)
        access(s, t, NW'(1) << model[s * NW + t], 1'b0, 1'b0, 0);

    // R6/R8: miss leaves record; fill points it at a victim
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NW; t++) begin
        int v;
        access(s, t, '0, 1'b0, 1'b0, 0);
        v = (s + 2 * t) % NW;
        fill(s, t, v);
        access(s, t, NW'(1) << v, 1'b0, 1'b0, 0);
      end

    // R5: several non-predicted ways match -> lowest one reported
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NW; t++) begin
        int p;
        p = model[s * NW + t];
        access(s, t, ~(NW'(1) << p), 1'b0, 1'b0, 0);
      end

    // R4: stray hit bits on non-enabled ways during first probe are ignored
    access(1, 2, 4'b1111 & ~(NW'(1) << model[1 * NW + 2]), 1'b0, 1'b0, 0);

    // R9: request held during flight is ignored
    access(2, 1, NW'(1) << model[2 * NW + 1], 1'b1, 1'b0, 0);
    access(3, 3, '0, 1'b1, 1'b0, 0);

    // R8: fill and fast-hit update on the same record, fill wins
    access(0, 3, NW'(1) << model[3], 1'b0, 1'b1, (model[3] + 1) % NW);
    access(0, 3, NW'(1) << model[3], 1'b0, 1'b0, 0);

    // R2: recheck all records against the model
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NW; t++)
        access(s, t, NW'(1) << model[s * NW + t], 1'b0, 1'b0, 0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule